// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the device-side consumer of a transmit descriptor ring that lives in host memory. The host places descriptors in the ring and posts a new producer position through a mailbox write. The engine sees that its own consumer position lags the producer. For each pending descriptor it reads the four 32-bit words of the 16-byte entry through a simple valid/ready memory read port. It then offers the buffer address, the byte length and the end-of-packet flag to a downstream packet reader. Each descriptor that the reader accepts moves the consumer position forward by one slot.

The block reports completed work to the host as a status-block write: the consumer position goes into the upper half of the fifth status word. These writes are batched. One is issued when enough descriptors have completed since the previous write, or when enough clock cycles have passed since the first of them, whichever comes first. An interrupt strobe accompanies every status write. A run-enable level gates the start of every new descriptor. The block also shows whether the host's producer position has filled the ring.

Top module: `txring_engine`

## Requirements
- R1: After reset the strobes `mem_rd_valid`, `pkt_valid`, `sts_wr_valid` and `irq` are low, both ring positions are zero and `ring_full` is low.
- R2: While a descriptor is being fetched, the engine issues exactly four reads at `RING_BASE + 16*cons + 4*k` for k = 0,1,2,3 in that order. Each read holds its address until `mem_rd_ready` is seen high.
- R3: The offered descriptor carries `pkt_addr = {word0, word1}` (word 0 is the upper half), `pkt_len = word2[31:16]` and `pkt_eop = word2[2]`. Every other bit of word 2, and all of word 3, has no effect.
- R4: `pkt_valid` and its fields stay constant until `pkt_ready` is high. Each acceptance advances the consumer position by one, modulo the ring depth of 512 (position 511 is followed by 0).
- R5: A mailbox write whose value equals the consumer position starts no memory read and offers no descriptor.
- R6: `ring_full` is high exactly when (producer + 1) mod 512 equals the consumer position.
- R7: A status write is a one-cycle `sts_wr_valid` with `sts_wr_addr = STATUS_BASE + 16` and `sts_wr_data` holding the consumer position in bits 31:16 and zero in bits 15:0. `irq` is high in exactly the same cycles.
- R8: When no tick expiry comes first, a status write happens in the cycle right after the 10th acceptance since the previous status write.
- R9: When fewer than 10 acceptances are pending, a status write happens 150 cycles after the clock edge of the first acceptance since the previous status write.
- R10: No status write happens while no acceptance is pending. An acceptance that falls in the same cycle as a status write is left out of the written position and counts toward the next write.
- R11: While `run_en` is low no new descriptor fetch starts. A fetch already in progress still completes, and mailbox writes are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run enable; low blocks new descriptor fetches |
| mbox_wr | input | 1 | Producer mailbox write strobe |
| mbox_idx | input | 9 | New producer position |
| ring_full | output | 1 | Producer position has left only the reserved empty slot |
| mem_rd_valid | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_ready | input | 1 | Read accepted; `mem_rd_data` valid in the same cycle |
| mem_rd_data | input | 32 | Returned descriptor word |
| pkt_valid | output | 1 | Descriptor offered to the packet reader |
| pkt_addr | output | 64 | Buffer address |
| pkt_len | output | 16 | Buffer length in bytes |
| pkt_eop | output | 1 | End-of-packet flag |
| pkt_ready | input | 1 | Packet reader accepts the offered descriptor |
| sts_wr_valid | output | 1 | Status word write strobe |
| sts_wr_addr | output | 32 | Byte address of the status word |
| sts_wr_data | output | 32 | Status word carrying the consumer position |
| irq | output | 1 | Interrupt strobe accompanying a status write |

## Verification
Two functions can fall in the same cycle: a status write fired by coalescing, and the acceptance of a descriptor by the packet reader. In that cycle the written position must still be the old one, and the counting for the next batch must already include the new acceptance. The bench provokes this collision in a dedicated sweep. One descriptor completes, which starts the tick window. A second descriptor is then held at the reader, and `pkt_ready` is released at a range of offsets around the 150-cycle expiry, so that at least one release lands on the write cycle. A behavioural model follows the pending count and the tick count on every clock. It judges the timing of every status write, the data it carries, and the fact that the colliding acceptance is counted toward the next batch.

// File: rtl/txr_pkg.sv
// Package txr_pkg
// Shared types and descriptor field positions for the transmit ring engine.
// Assumes 32-bit descriptor words and four words per descriptor.
package txr_pkg;

    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 4;
    localparam int DESC_BYTES  = DESC_WORDS * (WORD_W / 8);
    localparam int LEN_W       = 16;
    localparam int LEN_LSB     = 16;
    localparam int EOP_BIT     = 2;
    localparam int STS_POS_LSB = 16;
    localparam int STS_WORD    = 4;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_READ    = 2'd1,
        FS_PRESENT = 2'd2
    } fetch_state_t;

endpackage

// File: rtl/txr_ring_ptr.sv
// Module txr_ring_ptr
// Holds the producer position posted through the mailbox, and compares it
// with the consumer position to flag pending work and a full ring.
// Assumes the ring depth is a power of two, so positions wrap by width.
module txr_ring_ptr #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mbox_wr,
    input  logic [IDX_W-1:0] mbox_idx,
    input  logic [IDX_W-1:0] cons_idx,
    output logic             work_avail,
    output logic             ring_full
);

    logic [IDX_W-1:0] prod_q;
    logic [IDX_W-1:0] prod_next;

    // Latch the producer position on every mailbox write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (mbox_wr) begin
            prod_q <= mbox_idx;
        end
    end

    // Derive pending-work and full indications from the two positions
    always_comb begin
        prod_next  = prod_q + IDX_W'(1);
        work_avail = (prod_q != cons_idx);
        ring_full  = (prod_next == cons_idx);
    end

    // A full ring always has work pending (R6)
    p_full_implies_work_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> work_avail);

endmodule

// File: rtl/txr_fetch.sv
// Module txr_fetch
// Fetch sequencer: reads the four words of the descriptor at the consumer
// position, captures the address, length and end flag, offers them
// downstream and advances the consumer position on acceptance.
// Assumes read data is valid in the same cycle that mem_rd_ready is high.
module txr_fetch
    import txr_pkg::*;
#(
    parameter int                IDX_W     = 9,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RING_BASE = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              work_avail,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              pkt_valid,
    output logic [63:0]       pkt_addr,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_eop,
    input  logic              pkt_ready,
    output logic [IDX_W-1:0]  cons_idx,
    output logic              done_pulse
);

    localparam int SEL_W     = $clog2(DESC_WORDS);
    localparam int SLOT_SH   = $clog2(DESC_BYTES);
    localparam int WORD_SH   = $clog2(WORD_W / 8);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(DESC_WORDS - 1);

    fetch_state_t      state_q;
    logic [SEL_W-1:0]  sel_q;
    logic [IDX_W-1:0]  cons_q;
    logic [WORD_W-1:0] addr_hi_q;
    logic [WORD_W-1:0] addr_lo_q;
    logic [LEN_W-1:0]  len_q;
    logic              eop_q;
    logic [ADDR_W-1:0] slot_off;
    logic [ADDR_W-1:0] word_off;

    // Sequence idle -> four word reads -> offer -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            sel_q   <= '0;
            cons_q  <= '0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (run_en && work_avail) begin
                        state_q <= FS_READ;
                        sel_q   <= '0;
                    end
                end
                FS_READ: begin
                    if (mem_rd_ready) begin
                        if (sel_q == LAST_SEL) begin
                            state_q <= FS_PRESENT;
                        end else begin
                            sel_q <= sel_q + SEL_W'(1);
                        end
                    end
                end
                FS_PRESENT: begin
                    if (pkt_ready) begin
                        cons_q  <= cons_q + IDX_W'(1);
                        state_q <= FS_IDLE;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Capture the descriptor fields as their words arrive; the last word is dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            addr_lo_q <= '0;
            len_q     <= '0;
            eop_q     <= 1'b0;
        end else if (state_q == FS_READ && mem_rd_ready) begin
            case (sel_q)
                SEL_W'(0): addr_hi_q <= mem_rd_data;
                SEL_W'(1): addr_lo_q <= mem_rd_data;
                SEL_W'(2): begin
                    len_q <= mem_rd_data[LEN_LSB +: LEN_W];
                    eop_q <= mem_rd_data[EOP_BIT];
                end
                default: ;
            endcase
        end
    end

    // Form the word address and the handshake outputs
    always_comb begin
        slot_off     = ADDR_W'(cons_q) << SLOT_SH;
        word_off     = ADDR_W'(sel_q) << WORD_SH;
        mem_rd_addr  = RING_BASE + slot_off + word_off;
        mem_rd_valid = (state_q == FS_READ);
        pkt_valid    = (state_q == FS_PRESENT);
        pkt_addr     = {addr_hi_q, addr_lo_q};
        pkt_len      = len_q;
        pkt_eop      = eop_q;
        done_pulse   = pkt_valid && pkt_ready;
        cons_idx     = cons_q;
    end

    // A pending read keeps its address until accepted (R2)
    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // An offered descriptor is held unchanged until accepted (R4)
    p_pkt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_addr)
                                   && $stable(pkt_len) && $stable(pkt_eop));

    // The consumer position only ever steps by one slot (R4)
    p_cons_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cons_q) |-> cons_q == IDX_W'($past(cons_q) + IDX_W'(1)));

    // No pending work means no fetch is started (R5)
    p_no_fetch_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == FS_IDLE && !work_avail |=> !mem_rd_valid);

    // A low run enable blocks a new fetch (R11)
    p_idle_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == FS_IDLE && !run_en |=> !mem_rd_valid && !pkt_valid);

endmodule

// File: rtl/txr_coalesce.sv
// Module txr_coalesce
// Batches completion reports: counts accepted descriptors and elapsed cycles
// since the first of them, and issues a status write with interrupt when
// either limit is reached. Both counters restart after each write.
// Assumes at most one completion per cycle.
module txr_coalesce
    import txr_pkg::*;
#(
    parameter int                IDX_W       = 9,
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] STATUS_BASE = 32'h0002_0000,
    parameter int                TICK_LIMIT  = 150,
    parameter int                FRAME_LIMIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_pulse,
    input  logic [IDX_W-1:0]  cons_idx,
    output logic              sts_wr_valid,
    output logic [ADDR_W-1:0] sts_wr_addr,
    output logic [WORD_W-1:0] sts_wr_data,
    output logic              irq
);

    localparam int FC_W    = $clog2(FRAME_LIMIT + 1);
    localparam int TC_W    = $clog2(TICK_LIMIT + 1);
    localparam int POS_PAD = WORD_W - STS_POS_LSB - IDX_W;
    localparam logic [FC_W-1:0] FRAME_LIM_V = FC_W'(FRAME_LIMIT);
    localparam logic [TC_W-1:0] TICK_LIM_V  = TC_W'(TICK_LIMIT);
    localparam logic [ADDR_W-1:0] STS_OFF   = ADDR_W'(STS_WORD * (WORD_W / 8));

    logic [FC_W-1:0] frame_cnt;
    logic [TC_W-1:0] tick_cnt;
    logic            pending;
    logic            fire;

    // Decide whether a batch is due this cycle
    always_comb begin
        pending = (frame_cnt != '0);
        fire    = pending && ((frame_cnt >= FRAME_LIM_V) || (tick_cnt >= TICK_LIM_V));
    end

    // Count completions and elapsed cycles; restart both on a status write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            tick_cnt  <= '0;
        end else if (fire) begin
            frame_cnt <= done_pulse ? FC_W'(1) : '0;
            tick_cnt  <= '0;
        end else begin
            if (done_pulse) frame_cnt <= frame_cnt + FC_W'(1);
            if (pending)    tick_cnt  <= tick_cnt + TC_W'(1);
        end
    end

    // Present the status word write and its interrupt
    always_comb begin
        sts_wr_valid = fire;
        irq          = fire;
        sts_wr_addr  = STATUS_BASE + STS_OFF;
        sts_wr_data  = {{POS_PAD{1'b0}}, cons_idx, {STS_POS_LSB{1'b0}}};
    end

    // The completion counter never passes its limit (R8)
    p_frame_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= FRAME_LIM_V);

    // The tick counter never passes its limit (R9)
    p_tick_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= TICK_LIM_V);

    // Status writes are never back to back (R10)
    p_wb_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_valid |=> !sts_wr_valid);

    // Without a completion, nothing is pending right after a write (R10)
    p_wb_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_valid && !done_pulse |=> frame_cnt == '0 && tick_cnt == '0);

endmodule

// File: rtl/txring_engine.sv
// Module txring_engine
// Top of the transmit descriptor ring engine: producer register, fetch
// sequencer and completion coalescer.
// Assumes a power-of-two ring depth of at most 65536 entries.
module txring_engine
    import txr_pkg::*;
#(
    parameter int                RING_DEPTH  = 512,
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] RING_BASE   = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] STATUS_BASE = 32'h0002_0000,
    parameter int                TICK_LIMIT  = 150,
    parameter int                FRAME_LIMIT = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run_en,
    input  logic                          mbox_wr,
    input  logic [$clog2(RING_DEPTH)-1:0] mbox_idx,
    output logic                          ring_full,
    output logic                          mem_rd_valid,
    output logic [ADDR_W-1:0]             mem_rd_addr,
    input  logic                          mem_rd_ready,
    input  logic [31:0]                   mem_rd_data,
    output logic                          pkt_valid,
    output logic [63:0]                   pkt_addr,
    output logic [15:0]                   pkt_len,
    output logic                          pkt_eop,
    input  logic                          pkt_ready,
    output logic                          sts_wr_valid,
    output logic [ADDR_W-1:0]             sts_wr_addr,
    output logic [31:0]                   sts_wr_data,
    output logic                          irq
);

    localparam int IDX_W = $clog2(RING_DEPTH);

    logic [IDX_W-1:0] cons_idx;
    logic             work_avail;
    logic             done_pulse;

    txr_ring_ptr #(
        .IDX_W (IDX_W)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mbox_wr    (mbox_wr),
        .mbox_idx   (mbox_idx),
        .cons_idx   (cons_idx),
        .work_avail (work_avail),
        .ring_full  (ring_full)
    );

    txr_fetch #(
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W),
        .RING_BASE (RING_BASE)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .work_avail   (work_avail),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .pkt_valid    (pkt_valid),
        .pkt_addr     (pkt_addr),
        .pkt_len      (pkt_len),
        .pkt_eop      (pkt_eop),
        .pkt_ready    (pkt_ready),
        .cons_idx     (cons_idx),
        .done_pulse   (done_pulse)
    );

    txr_coalesce #(
        .IDX_W       (IDX_W),
        .ADDR_W      (ADDR_W),
        .STATUS_BASE (STATUS_BASE),
        .TICK_LIMIT  (TICK_LIMIT),
        .FRAME_LIMIT (FRAME_LIMIT)
    ) u_coal (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_pulse   (done_pulse),
        .cons_idx     (cons_idx),
        .sts_wr_valid (sts_wr_valid),
        .sts_wr_addr  (sts_wr_addr),
        .sts_wr_data  (sts_wr_data),
        .irq          (irq)
    );

    // A status write and its interrupt are always paired (R7)
    p_irq_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == sts_wr_valid);

endmodule

// File: tb/txring_engine_tb.sv
// Bench for txring_engine: a behavioural reference model, compared on every clock.
module txring_engine_tb;

    localparam int          DEPTH = 512;
    localparam int          TK    = 150;
    localparam int          FR    = 10;
    localparam logic [31:0] RB    = 32'h0001_0000;
    localparam logic [31:0] SB    = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        mbox_wr = 1'b0;
    logic [8:0]  mbox_idx = '0;
    logic        ring_full;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b1;
    logic [31:0] mem_rd_data;
    logic        pkt_valid;
    logic [63:0] pkt_addr;
    logic [15:0] pkt_len;
    logic        pkt_eop;
    logic        pkt_ready = 1'b1;
    logic        sts_wr_valid;
    logic [31:0] sts_wr_addr;
    logic [31:0] sts_wr_data;
    logic        irq;

    int total = 0, bad = 0;
    int m_cons = 0, m_prod = 0, m_fr = 0, m_tick = 0, m_wcnt = 0;
    bit m_busy = 0;
    int handoffs = 0, wbs = 0, colls = 0;
    int mem_mode = 0, pkt_mode = 0, cyc = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    txring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mbox_wr(mbox_wr), .mbox_idx(mbox_idx),
        .ring_full(ring_full), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data), .pkt_valid(pkt_valid),
        .pkt_addr(pkt_addr), .pkt_len(pkt_len), .pkt_eop(pkt_eop), .pkt_ready(pkt_ready),
        .sts_wr_valid(sts_wr_valid), .sts_wr_addr(sts_wr_addr), .sts_wr_data(sts_wr_data),
        .irq(irq)
    );

    // Descriptor content in host memory, a function of slot and word number
    function automatic logic [31:0] dword(int idx, int w);
        case (w)
            0: return 32'h0000_0A00 | 32'(idx);
            1: return 32'h8000_0000 | (32'(idx) << 6);
            2: return (32'((idx * 7 + 64) & 16'hFFFF) << 16) | ((idx % 3 == 0) ? 32'h4 : 32'h0)
                      | 32'h0000_0001;
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    always_comb mem_rd_data = dword(int'(((mem_rd_addr - RB) >> 4) & 32'h1FF),
                                    int'((mem_rd_addr >> 2) & 32'h3));

    task automatic chk(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Ready patterns for the memory port and the packet reader
    initial forever begin
        @(posedge clk); #1;
        cyc++;
        mem_rd_ready = (mem_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
        pkt_ready    = (pkt_mode == 0) ? 1'b1 : (pkt_mode == 1) ? ((cyc % 5) >= 2) : 1'b0;
    end

    // Reference model, compared with the design outputs on every clock
    always @(negedge clk) begin
        bit exp_wb, hand, exp_full;
        if (!rst_n) begin
            chk(!mem_rd_valid && !pkt_valid && !sts_wr_valid && !irq && !ring_full,
                "R1 reset strobes", {mem_rd_valid, pkt_valid, sts_wr_valid, irq, ring_full}, 0);
            m_cons = 0; m_prod = 0; m_fr = 0; m_tick = 0; m_busy = 0; m_wcnt = 0;
        end else begin
            exp_wb = (m_fr > 0) && (m_fr >= FR || m_tick >= TK);
            hand = pkt_valid && pkt_ready;
            chk(sts_wr_valid == exp_wb, "R8 R9 R10 status write timing", sts_wr_valid, exp_wb);
            chk(irq == exp_wb, "R7 irq", irq, exp_wb);
            if (sts_wr_valid) begin
                chk(sts_wr_data == 32'(m_cons) << 16, "R7 status data", sts_wr_data,
                    32'(m_cons) << 16);
                chk(sts_wr_addr == SB + 32'd16, "R7 status address", sts_wr_addr, SB + 32'd16);
            end
            exp_full = (((m_prod + 1) % DEPTH) == m_cons);
            chk(ring_full == exp_full, "R6 ring_full", ring_full, exp_full);
            if (!m_busy) begin
                chk(!mem_rd_valid && !pkt_valid, "R5 R11 idle activity",
                    {mem_rd_valid, pkt_valid}, 0);
            end else if (m_wcnt < 4) begin
                chk(mem_rd_valid && !pkt_valid, "R2 read phase", {mem_rd_valid, pkt_valid}, 2);
                chk(mem_rd_addr == RB + 32'(m_cons * 16 + m_wcnt * 4), "R2 read address",
                    mem_rd_addr, RB + 32'(m_cons * 16 + m_wcnt * 4));
            end else begin
                chk(pkt_valid && !mem_rd_valid, "R4 offer phase", {mem_rd_valid, pkt_valid}, 1);
                chk(pkt_addr == {dword(m_cons, 0), dword(m_cons, 1)}, "R3 pkt_addr",
                    pkt_addr, {dword(m_cons, 0), dword(m_cons, 1)});
                chk(pkt_len == 16'((m_cons * 7 + 64) & 16'hFFFF), "R3 pkt_len", pkt_len,
                    (m_cons * 7 + 64) & 16'hFFFF);
                chk(pkt_eop == (m_cons % 3 == 0), "R3 pkt_eop", pkt_eop, m_cons % 3 == 0);
            end
            if (exp_wb && hand) colls++;
            if (exp_wb) begin
                m_fr = hand ? 1 : 0; m_tick = 0; wbs++;
            end else begin
                if (m_fr > 0) m_tick++;
                if (hand) m_fr++;
            end
            if (mem_rd_valid && mem_rd_ready) m_wcnt++;
            if (hand) begin
                m_cons = (m_cons + 1) % DEPTH; m_busy = 0; handoffs++;
            end else if (!m_busy && run_en && m_cons != m_prod) begin
                m_busy = 1; m_wcnt = 0;
            end
            if (mbox_wr) m_prod = int'(mbox_idx);
        end
    end

    task automatic post(int v);
        @(posedge clk); #1;
        mbox_wr = 1'b1; mbox_idx = 9'(v);
        @(posedge clk); #1;
        mbox_wr = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        while (!(m_cons == m_prod && !m_busy && m_fr == 0)) @(negedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        int h, w0, base;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        run_en = 1'b1;
        // R9: three descriptors, reported by tick expiry
        post(3);
        drain();
        chk(wbs == 1 && m_cons == 3, "R9 single tick report", wbs, 1);
        // R5: mailbox equal to the consumer position
        h = handoffs;
        post(3);
        wait_cycles(20);
        chk(handoffs == h, "R5 equal mailbox", handoffs, h);
        // R8: long stream with stalls on both sides
        mem_mode = 1; pkt_mode = 1; w0 = wbs;
        post(30);
        drain();
        chk(wbs - w0 >= 3, "R8 frame-limited reports", wbs - w0, 3);
        // R11: stop between descriptors, mailbox still recorded
        post(60);
        wait_cycles(15);
        run_en = 1'b0;
        wait_cycles(40);
        h = handoffs;
        wait_cycles(50);
        chk(handoffs == h, "R11 stopped", handoffs, h);
        post(70);
        run_en = 1'b1;
        drain();
        chk(m_cons == 70, "R11 resume to recorded producer", m_cons, 70);
        // R10: collide a status write with an acceptance
        mem_mode = 0;
        for (int off = 140; off <= 160; off++) begin
            base = m_cons;
            pkt_mode = 0;
            post(base + 1);
            while (m_cons != base + 1) @(negedge clk);
            @(posedge clk); #1;
            pkt_mode = 2;
            post(base + 2);
            wait_cycles(off);
            pkt_mode = 0;
            drain();
        end
        chk(colls > 0, "R10 collision provoked", colls, 1);
        // R4: wrap from 511 to 0
        mem_mode = 1; pkt_mode = 1;
        post(500);
        drain();
        post(5);
        drain();
        chk(m_cons == 5, "R4 wrap", m_cons, 5);
        // R6: fill the ring, then drain it completely
        run_en = 1'b0;
        post(4);
        wait_cycles(2);
        chk(ring_full == 1'b1, "R6 full ring", ring_full, 1);
        run_en = 1'b1;
        drain();
        chk(m_cons == 4 && ring_full == 1'b0, "R4 R6 drained", m_cons, 4);
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule